// File: doc/BRIEF.md
# Counter-Ramp Conversion Controller

This block is the digital half of a staircase analog-to-digital converter. It drives a parameterised up-counter onto an external DAC and watches a single comparator bit that stays high while the DAC level is still under the analog input. When a start request is accepted, the ramp begins at code zero. The code rises by one step per clock until the comparator drops. The code reached at that moment is captured into a separate result register, a one-clock done pulse is raised, and the counter returns to zero for the next ramp.

Conversion time grows with the input amplitude. A ramp that never trips the comparator stops at the all-ones code, so the longest conversion covers 2^N-1 count steps plus one capture clock. The sample period must cover that much time. A start request that arrives during a ramp is dropped. The busy output marks the span from acceptance to completion.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While rst_ni is low, dac_code_o, result_o, busy_o and done_o are all 0.
- R2: A start_i sampled high while busy_o is low starts a ramp. On the next cycle busy_o is 1 and dac_code_o is 0.
- R3: While busy_o is 1, cmp_below_i is 1 and dac_code_o is below all ones, dac_code_o rises by exactly one on each clock.
- R4: While busy_o is 1, a cmp_below_i of 0 ends the ramp. On the next cycle done_o is 1, result_o holds the code from the capture cycle, dac_code_o is 0 and busy_o is 0.
- R5: If dac_code_o is all ones and cmp_below_i is still 1, the ramp ends on the next clock with result_o at all ones. The code never wraps.
- R6: done_o is high for exactly one cycle per conversion and is never high together with busy_o.
- R7: result_o changes only in a cycle where done_o rises, and it holds its value across later ramps until the next completion.
- R8: A start_i that is high while busy_o is 1 has no effect. The running ramp keeps its timing and result, and no extra conversion follows it.
- R9: A start_i sampled in the cycle where done_o is high is accepted and begins a new ramp from code 0.
- R10: With a comparator that trips once the code reaches t, done_o rises min(t, 2^N-1)+1 clocks after the clock that accepted start_i.
- R11: While busy_o is 0, dac_code_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled on the clock |
| cmp_below_i | input | 1 | Comparator: 1 while the DAC level is under the analog input |
| dac_code_o | output | CODE_W | Ramp code driven to the DAC |
| busy_o | output | 1 | High from acceptance of a start until completion |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | CODE_W | Captured conversion result |

## Verification
Completion of one ramp and acceptance of the next start can fall in the same cycle, because busy_o is already low while done_o is high. The bench holds start_i high in the cycle where it sees done_o. It then expects busy_o high on the following cycle, dac_code_o back at 0, no second done pulse, and the right result and latency for the new threshold. A start pulse in the middle of a ramp is also checked against unchanged latency, and against no further ramp after the first one ends.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_fsm.sv
module ramp_fsm
  import ramp_adc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cmp_below_i,
  input  logic at_max_i,
  output logic busy_o,
  output logic inc_o,
  output logic finish_o
);
  ramp_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    inc_o    = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RAMP;
      ST_RAMP: begin
        // stop on comparator trip or at full scale
        if (!cmp_below_i || at_max_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          inc_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q == ST_RAMP);
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] count_o,
  output logic              at_max_o
);
  localparam logic [CODE_W-1:0] MaxCode = {CODE_W{1'b1}};

  logic [CODE_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (inc_i)   count_q <= count_q + 1'b1;
  end

  assign count_o  = count_q;
  assign at_max_o = (count_q == MaxCode);
endmodule

// File: rtl/result_reg.sv
module result_reg #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] result_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) result_o <= code_i;
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmp_below_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o
);
  logic inc, finish, at_max;

  ramp_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cmp_below_i (cmp_below_i),
    .at_max_i    (at_max),
    .busy_o      (busy_o),
    .inc_o       (inc),
    .finish_o    (finish)
  );

  ramp_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (finish),
    .inc_i    (inc),
    .count_o  (dac_code_o),
    .at_max_o (at_max)
  );

  result_reg #(.CODE_W(CODE_W)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (finish),
    .code_i   (dac_code_o),
    .result_o (result_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cmp_below_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] result_o
);
  localparam logic [CODE_W-1:0] MaxCode = {CODE_W{1'b1}};

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (dac_code_o == '0 && result_o == '0 && !busy_o && !done_o));

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && dac_code_o == '0));

  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_below_i && dac_code_o != MaxCode)
      |=> (busy_o && dac_code_o == CODE_W'($past(dac_code_o) + 1'b1)));

  // R4
  trip_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmp_below_i)
      |=> (done_o && !busy_o && dac_code_o == '0 && result_o == $past(dac_code_o)));

  // R5
  full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmp_below_i && dac_code_o == MaxCode)
      |=> (done_o && result_o == MaxCode && dac_code_o == '0));

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cmp_below_i && dac_code_o != MaxCode) |=> busy_o);

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> dac_code_o == '0);
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmp_below_i (cmp_below_i),
  .dac_code_o  (dac_code_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .result_o    (result_o)
);

// File: tb/ramp_adc_ctrl_tb_top.sv
module ramp_adc_ctrl_tb_top;
  localparam int CodeW  = 4;
  localparam int MaxC   = (1 << CodeW) - 1;
  localparam int NVec   = 8;
  localparam int Thr[NVec]    = '{0, 1, 5, 9, 14, 15, 16, 3};
  localparam int ExpRes[NVec] = '{0, 1, 5, 9, 14, 15, 15, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_below;
  logic [CodeW-1:0] dac_code, result;
  logic busy, done;
  int thr = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // comparator model: DAC still below input while code < threshold
  assign cmp_below = (int'(dac_code) < thr);

  ramp_adc_ctrl #(.CODE_W(CodeW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .cmp_below_i (cmp_below),
    .dac_code_o  (dac_code),
    .busy_o      (busy),
    .done_o      (done),
    .result_o    (result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // start at a negedge, walk the ramp, check timing and result
  task automatic convert(input int t, input int exp_res, input int mid_start);
    int n;
    bit ramp_ok;
    int prev_res;
    prev_res = int'(result);
    thr   = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && dac_code == '0, "R2", int'(dac_code), 0);
    chk(int'(result) == prev_res, "R7", int'(result), prev_res);
    n = 1;
    ramp_ok = 1'b1;
    while (!done && n < 64) begin
      if (busy && int'(dac_code) != n - 1) ramp_ok = 1'b0;
      start = (mid_start != 0 && n == mid_start);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(ramp_ok, "R3", 0, 0);
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    chk(n == exp_res + 2, "R10 latency", n, exp_res + 2);
    chk(int'(result) == exp_res, (exp_res == MaxC) ? "R5" : "R4", int'(result), exp_res);
    chk(!busy && dac_code == '0, "R4 cleared", int'(dac_code), 0);
    @(negedge clk);
    chk(!done, "R6", int'(done), 0);
    chk(!busy && dac_code == '0, "R11", int'(busy), 0);
    chk(int'(result) == exp_res, "R7", int'(result), exp_res);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk(dac_code == '0 && result == '0 && !busy && !done, "R1", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && dac_code == '0, "R11", int'(dac_code), 0);

    for (int i = 0; i < NVec; i++) convert(Thr[i], ExpRes[i], 0);

    // R8: start pulse mid-ramp is dropped
    convert(10, 10, 3);
    for (int k = 0; k < 3; k++) begin
      chk(!busy && !done, "R8 no extra ramp", int'(busy), 0);
      @(negedge clk);
    end

    // R9: start in the done cycle
    thr = 4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(int'(result) == 4, "R9 first", int'(result), 4);
    thr = 7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && dac_code == '0, "R9 accepted", int'(busy), 1);
    for (int k = 0; k < 8; k++) @(negedge clk);
    chk(done && int'(result) == 7, "R9 result", int'(result), 7);
    @(negedge clk);

    // R1: asynchronous reset in mid-ramp
    thr = 12;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dac_code == '0 && result == '0 && !busy && !done, "R1 mid-ramp", int'(dac_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    convert(6, 6, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule